// File: doc/BRIEF.md
# Pin-Selectable GPIO Controller with Single Interrupt Source

This block is a 22-pin general-purpose I/O controller that sits on a simple 32-bit register bus. Software sets pad output levels through a data-out register and chooses, pin by pin, whether each pad drives or listens through a direction register. It observes pad levels through a read-only data-in view, which is fed by a two-flop synchroniser.

A single trigger-configuration register names one pin by a 6-bit index and selects how that pin raises the block's one interrupt line. The modes are off, active-low level, active-high level and any-edge. In edge mode a detected change latches into a sticky pending flag. The flag holds the interrupt high until software rewrites the trigger-configuration register. Software that watches several pins retargets the index in turn.

The bus request channel uses valid/ready. Ready is always high, so a request is accepted in the cycle its valid is high. A read returns its data on a response channel exactly one cycle later. The response has no ready: the requester must be able to take it in that cycle.

Top module: `gpio_trig_ctrl`

## Requirements
- R1: After reset, data-out and direction are zero, so every pin is an input (`pad_oe` all zero) and `pad_out` is zero. The trigger mode is off and the index is 0, so `irq` is low and the trigger register reads 0.
- R2: Offset 0x08 is data-out. A write stores bits [21:0], which drive `pad_out` from the next cycle. A read returns them with bits [31:22] zero.
- R3: Offset 0x10 is direction. Bit n = 1 makes pin n an output and bit n = 0 makes it an input. `pad_oe` follows the stored bits from the next cycle, and a read returns bits [21:0] with [31:22] zero.
- R4: Offset 0x00 is data-in. It returns the synchronised `pad_in` levels whatever the direction settings. A read issued two cycles after a pad change returns the new level. Writes to 0x00 change nothing.
- R5: Offset 0x18 is trigger configuration. Bits [5:0] are the pin index and bits [7:6] are the mode: 0 off, 1 low level, 2 high level, 3 edge. A read returns bits [7:0] with [31:8] zero.
- R6: In mode 1 with an index below 22, `irq` is high while the synchronised selected pin is 0, and low while it is 1.
- R7: In mode 2 with an index below 22, `irq` is high while the synchronised selected pin is 1, and low while it is 0.
- R8: In mode 3, any rising or falling change of the synchronised selected pin sets a pending flag that drives `irq`. The flag stays set until the next write to 0x18, and that write clears it in the following cycle.
- R9: In mode 0, `irq` stays low whatever the pads do.
- R10: An index of 22 to 63 never raises `irq`, in any mode.
- R11: Offsets other than 0x00, 0x08, 0x10 and 0x18 read as zero, and writes to them change no register.
- R12: `req_ready` is always 1. Every accepted read produces `rsp_valid` for exactly one cycle, one cycle after acceptance. `rsp_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 22 | Pad input levels (asynchronous) |
| pad_out | output | 22 | Pad output levels |
| pad_oe | output | 22 | Pad output enables (1 = drive) |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the sticky edge flag with both a falling and a rising change, and checks that the flag holds across idle cycles and drops only after a trigger-register write. A design that cleared the flag when the pad returned, or saw only one edge direction, would drop or miss the interrupt. It also selects the out-of-range indices 22 and 63 while toggling every pad, which catches an index mux that wraps or truncates onto a real pin and fires falsely. Reads of unused bits, of holes in the map and of a written data-in offset expose decoding that aliases or stores where it should not.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int PIN_IDX_W = 6;
  localparam int MODE_W    = 2;
  localparam int CFG_W     = PIN_IDX_W + MODE_W;

  // Register offsets; software depends on these positions.
  localparam logic [ADDR_W-1:0] OFF_DIN  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DOUT = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_TRIG = 8'h18;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_LOW  = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_EDGE = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 22,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_trig_pkg::*;
#(
  parameter int NUM_PINS = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [NUM_PINS-1:0]  din_sync,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_PINS-1:0]  dout_q,
  output logic [NUM_PINS-1:0]  dir_q,
  output logic [PIN_IDX_W-1:0] cfg_pin,
  output trig_mode_e           cfg_mode,
  output logic                 cfg_wr
);
  logic wr_en, rd_en;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en  = req_valid &&  req_write;
  assign rd_en  = req_valid && !req_write;
  assign cfg_wr = wr_en && (req_addr == OFF_TRIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= '0;
      cfg_pin  <= '0;
      cfg_mode <= TRIG_OFF;
    end else if (wr_en) begin
      unique case (req_addr)
        OFF_DOUT: dout_q <= req_wdata[NUM_PINS-1:0];
        OFF_DIR:  dir_q  <= req_wdata[NUM_PINS-1:0];
        OFF_TRIG: begin
          cfg_pin  <= req_wdata[PIN_IDX_W-1:0];
          cfg_mode <= trig_mode_e'(req_wdata[CFG_W-1:PIN_IDX_W]);
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (req_addr)
      OFF_DIN:  rd_mux = DATA_W'(din_sync);
      OFF_DOUT: rd_mux = DATA_W'(dout_q);
      OFF_DIR:  rd_mux = DATA_W'(dir_q);
      OFF_TRIG: rd_mux = DATA_W'({cfg_mode, cfg_pin});
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_trig_pkg::*;
#(
  parameter int NUM_PINS = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PINS-1:0]  sync_in,
  input  logic [PIN_IDX_W-1:0] cfg_pin,
  input  trig_mode_e           cfg_mode,
  input  logic                 cfg_wr,
  output logic                 irq
);
  logic [NUM_PINS-1:0] prev_q;
  logic pend_q, sel_cur, sel_prev, pin_ok, edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  always_comb begin
    sel_cur  = 1'b0;
    sel_prev = 1'b0;
    pin_ok   = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (cfg_pin == PIN_IDX_W'(i)) begin
        sel_cur  = sync_in[i];
        sel_prev = prev_q[i];
        pin_ok   = 1'b1;
      end
    end
  end

  assign edge_hit = pin_ok && (cfg_mode == TRIG_EDGE) && (sel_cur ^ sel_prev);

  always_ff @(posedge clk) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (cfg_wr)   pend_q <= 1'b0;
    else if (edge_hit) pend_q <= 1'b1;
  end

  always_comb begin
    unique case (cfg_mode)
      TRIG_LOW:  irq = pin_ok && !sel_cur;
      TRIG_HIGH: irq = pin_ok &&  sel_cur;
      TRIG_EDGE: irq = pend_q;
      default:   irq = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_trig_ctrl.sv
module gpio_trig_ctrl
  import gpio_trig_pkg::*;
#(
  parameter int NUM_PINS    = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq
);
  logic [NUM_PINS-1:0]  din_sync;
  logic [PIN_IDX_W-1:0] cfg_pin;
  trig_mode_e           cfg_mode;
  logic                 cfg_wr;

  assign req_ready = 1'b1;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(din_sync)
  );

  gpio_regfile #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .din_sync(din_sync),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dout_q(pad_out), .dir_q(pad_oe),
    .cfg_pin(cfg_pin), .cfg_mode(cfg_mode), .cfg_wr(cfg_wr)
  );

  gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .sync_in(din_sync),
    .cfg_pin(cfg_pin), .cfg_mode(cfg_mode), .cfg_wr(cfg_wr),
    .irq(irq)
  );
endmodule

// File: rtl/gpio_trig_ctrl_chk.sv
module gpio_trig_ctrl_chk
  import gpio_trig_pkg::*;
#(
  parameter int NUM_PINS = 22
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [ADDR_W-1:0]    req_addr,
  input logic                 rsp_valid,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [NUM_PINS-1:0]  pad_oe,
  input logic                 irq,
  input logic [PIN_IDX_W-1:0] cfg_pin,
  input trig_mode_e           cfg_mode
);
  // R12
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
  // R12
  read_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  // R12
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr == OFF_DOUT) |=> $stable(pad_out));
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_addr == OFF_DIR) |=> $stable(pad_oe));
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == TRIG_OFF) |-> !irq);
  // R10
  bad_pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pin >= PIN_IDX_W'(NUM_PINS)) |-> !irq);
  // R8
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && cfg_mode == TRIG_EDGE && !(req_valid && req_write && req_addr == OFF_TRIG))
      |=> irq);
endmodule

bind gpio_trig_ctrl gpio_trig_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq),
  .cfg_pin(cfg_pin), .cfg_mode(cfg_mode)
);

// File: tb/gpio_trig_ctrl_test.sv
module gpio_trig_ctrl_test;
  localparam int NP = 22;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_trig_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // {write, addr, wdata, expected read data}
  localparam logic [72:0] VECS [NV] = '{
    {1'b0, 8'h08, 32'h0,        32'h0},        // R1 data-out reset
    {1'b0, 8'h10, 32'h0,        32'h0},        // R1 direction reset
    {1'b0, 8'h18, 32'h0,        32'h0},        // R1 trigger reset
    {1'b1, 8'h08, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h08, 32'h0,        32'h003FFFFF}, // R2
    {1'b1, 8'h10, 32'hA5A5A5A5, 32'h0},
    {1'b0, 8'h10, 32'h0,        32'h0025A5A5}, // R3
    {1'b1, 8'h18, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h18, 32'h0,        32'h000000FF}, // R5
    {1'b1, 8'h04, 32'h12345678, 32'h0},
    {1'b0, 8'h04, 32'h0,        32'h0},        // R11
    {1'b0, 8'h0C, 32'h0,        32'h0},        // R11
    {1'b1, 8'h00, 32'hFFFFFFFF, 32'h0},
    {1'b0, 8'h00, 32'h0,        32'h0},        // R4 write ignored
    {1'b1, 8'h18, 32'h00000000, 32'h0},
    {1'b0, 8'h18, 32'h0,        32'h0}         // R5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid after read", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    chk("R12 rsp_valid one cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    chk("R1 pad_out", 32'(pad_out), 32'h0);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R12 ready", 32'(req_ready), 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][72]) wr(VECS[i][71:64], VECS[i][63:32]);
      else begin
        rd(VECS[i][71:64], d);
        chk($sformatf("table row %0d (R1/R2/R3/R4/R5/R11)", i), d, VECS[i][31:0]);
      end
    end
    chk("R2 pad_out drive", 32'(pad_out), 32'h003FFFFF);
    chk("R3 pad_oe drive", 32'(pad_oe), 32'h0025A5A5);

    // R4: data-in reads pads regardless of direction, two cycles after change
    @(negedge clk); pad_in = 22'h2AAAAA;
    settle(1);
    rd(8'h00, d);
    chk("R4 data-in", d, 32'h002AAAAA);

    // R6: low-level on pin 5
    wr(8'h18, 32'h45);
    settle(1);
    chk("R6 pin high no irq", 32'(irq), 32'h0);
    pad_in[5] = 1'b0; settle(3);
    chk("R6 pin low irq", 32'(irq), 32'h1);

    // R7: high-level on pin 5
    wr(8'h18, 32'h85);
    settle(1);
    chk("R7 pin low no irq", 32'(irq), 32'h0);
    pad_in[5] = 1'b1; settle(3);
    chk("R7 pin high irq", 32'(irq), 32'h1);

    // R9: off mode
    wr(8'h18, 32'h05);
    settle(1);
    chk("R9 off high", 32'(irq), 32'h0);
    pad_in[5] = 1'b0; settle(3);
    chk("R9 off low", 32'(irq), 32'h0);
    pad_in[5] = 1'b1; settle(3);

    // R8: edge mode, falling then rising
    wr(8'h18, 32'hC5);
    settle(3);
    chk("R8 no edge", 32'(irq), 32'h0);
    pad_in[5] = 1'b0; settle(4);
    chk("R8 falling edge", 32'(irq), 32'h1);
    settle(20);
    chk("R8 sticky", 32'(irq), 32'h1);
    wr(8'h18, 32'hC5);
    chk("R8 cleared by write", 32'(irq), 32'h0);
    pad_in[5] = 1'b1; settle(4);
    chk("R8 rising edge", 32'(irq), 32'h1);
    pad_in[5] = 1'b0; settle(4);
    chk("R8 stays after return", 32'(irq), 32'h1);
    wr(8'h18, 32'hC5);
    chk("R8 cleared again", 32'(irq), 32'h0);

    // R10: out-of-range indices
    wr(8'h18, 32'hD6);
    pad_in = '1; settle(4);
    pad_in = '0; settle(4);
    chk("R10 edge pin 22", 32'(irq), 32'h0);
    wr(8'h18, 32'hBF);
    pad_in = '1; settle(4);
    chk("R10 high pin 63", 32'(irq), 32'h0);
    wr(8'h18, 32'h7F);
    pad_in = '0; settle(4);
    chk("R10 low pin 63", 32'(irq), 32'h0);

    // R11: unmapped write left registers intact
    wr(8'h14, 32'h0);
    rd(8'h08, d);
    chk("R11 data-out kept", d, 32'h003FFFFF);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule